// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block watches one asynchronous serial line and turns each frame on it into a short series of typed events. The line is first brought into the clock domain. A falling edge seen while idle opens a frame. From then on every bit is sampled at the middle of its period. The period is set by a clocks-per-bit divisor and is timed from the detected edge. Between 5 and 9 data bits are assembled, in LSB-first or MSB-first order. An optional parity bit is checked in one of four modes. A single stop bit is checked at the midpoint of a stop interval that is 0.5, 1, 1.5 or 2 bit periods long.

Each element of the frame is reported as an event on the output: a one-cycle `evt_valid` pulse carrying a 3-bit type and a 9-bit payload. The serial line cannot be paused, so the event output has no ready input and applies no back-pressure. The consumer must accept every pulse in the cycle it appears. Two pulses never arrive in adjacent cycles. The whole line can be inverted, which makes the idle level low. Alternatively, only the data and parity bits can be inverted, while the start and stop bits keep their normal levels. Settings are captured only while the receiver is idle.

Top module: `serial_frame_rx`

## Requirements
- R1: The line passes through a two-flop synchroniser. A high-to-low transition of the logical line while idle starts a frame. The start bit is sampled half a bit period later. If it reads 0, an event of type 0 with payload 0 is emitted.
- R2: If the start bit reads 1, an event of type 4 with payload 1 is emitted. The receiver then returns to idle and reports nothing more for that frame.
- R3: `cfg_data_bits` selects 5 to 9 data bits; values below 5 count as 5 and values above 9 count as 9. After the last data bit, one event of type 1 carries the assembled value, with every payload bit at or above the width cleared.
- R4: With `cfg_msb_first` = 0, the first data bit received is payload bit 0. With `cfg_msb_first` = 1, the first data bit received is the top bit of the configured width.
- R5: `cfg_parity` selects the parity mode: 0 none, 1 odd, 2 even, 3 mark (always 1), 4 space (always 0). Codes 5 to 7 behave as none. With no parity, the stop bit follows the last data bit and no parity event is emitted.
- R6: Odd and even parity count the ones in the data bits plus the parity bit. A matching parity bit gives an event of type 2 whose payload is the received bit. A mismatch gives an event of type 6 whose payload bit 1 is the expected value and bit 0 is the received value.
- R7: `cfg_stop` selects the stop length: 0 half, 1 one, 2 one and a half, 3 two bit periods. The stop bit is sampled at the middle of that interval, which lies half a period plus half the stop length after the previous sample. A 1 gives an event of type 3 with payload 1. A 0 gives an event of type 5 with payload 0.
- R8: With `cfg_invert_line` = 1, the whole line is inverted before synchronisation, so the idle level is low and all decoding works on the inverted line.
- R9: With `cfg_invert_data` = 1, only the data and parity bits are inverted after sampling. Payloads and parity checks use the inverted values, and the start and stop bits are read without inversion.
- R10: Every setting except `cfg_invert_line` is captured while idle and held for the whole frame, so changes made during a frame have no effect until the frame ends.
- R11: After reset `evt_valid` is 0. Every event lasts exactly one cycle, and no two events occur in adjacent cycles.
- R12: Successive bit samples are exactly `cfg_clks_per_bit` cycles apart, so the data event follows the start event by data-bits × clocks-per-bit cycles. `cfg_clks_per_bit` must be at least 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial input |
| cfg_clks_per_bit | input | CNT_W | Clock cycles per bit period (at least 4) |
| cfg_data_bits | input | 4 | Data bits per frame, 5 to 9 |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| cfg_msb_first | input | 1 | Data bits arrive most significant first |
| cfg_invert_line | input | 1 | Invert the whole line |
| cfg_invert_data | input | 1 | Invert data and parity bits only |
| evt_valid | output | 1 | One-cycle event strobe, no back-pressure |
| evt_type | output | 3 | Event type code |
| evt_data | output | 9 | Event payload |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor field, two synchroniser stages and a 9-bit maximum width. It drives a divisor of 8, which keeps a frame near a hundred cycles. That short frame makes it affordable to sweep every data width against every parity mode and both bit orders, and to send all 256 byte values through the 8-bit path. It also leaves room for every stop length with good and bad stop levels, forced parity mismatches, a glitch start, both inversion options, and a frame whose settings change mid-flight. Because the divisor is fixed, the spacing of the start, data and stop events can be checked to the exact cycle.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;
  typedef enum logic [2:0] {
    EV_START     = 3'd0,
    EV_DATA      = 3'd1,
    EV_PARITY    = 3'd2,
    EV_STOP      = 3'd3,
    EV_BAD_START = 3'd4,
    EV_BAD_STOP  = 3'd5,
    EV_PAR_ERR   = 3'd6
  } evt_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_e;

  typedef enum logic [1:0] {
    STOP_HALF     = 2'd0,
    STOP_ONE      = 2'd1,
    STOP_ONE_HALF = 2'd2,
    STOP_TWO      = 2'd3
  } stop_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } st_e;

  localparam int unsigned MIN_BITS = 5;
endpackage

// File: rtl/sfr_line_sync.sv
`timescale 1ns/1ps
module sfr_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic invert,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  // Inversion sits ahead of the flops so that flipping the polarity together
  // with the raw level produces no glitch on the logical line.
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= rx_line ^ invert;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], rx_line ^ invert};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign line = chain[STAGES-1];
  assign fall = prev & ~line;
endmodule

// File: rtl/sfr_bit_timer.sv
`timescale 1ns/1ps
module sfr_bit_timer #(
  parameter int unsigned TMR_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             tick
);
  logic [TMR_W-1:0] cnt;
  logic             run;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      run <= 1'b1;
    end else if (tick) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R12: sample points are separated by at least two cycles
  assert_tick_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sfr_frame_ctrl.sv
`timescale 1ns/1ps
module sfr_frame_ctrl
  import sfr_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned MAX_BITS = 9,
  parameter int unsigned TMR_W    = CNT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line,
  input  logic                fall,
  input  logic                tick,
  input  logic [CNT_W-1:0]    cfg_clks_per_bit,
  input  logic [3:0]          cfg_data_bits,
  input  logic [2:0]          cfg_parity,
  input  logic [1:0]          cfg_stop,
  input  logic                cfg_msb_first,
  input  logic                cfg_invert_data,
  output logic                tmr_load,
  output logic [TMR_W-1:0]    tmr_val,
  output logic                evt_valid,
  output logic [2:0]          evt_type,
  output logic [MAX_BITS-1:0] evt_data
);
  localparam int unsigned NB_W = 4;

  st_e                 state, nxt;
  logic [CNT_W-1:0]    cpb_q;
  logic [NB_W-1:0]     nb_q, nb_in;
  par_e                par_q;
  stop_e               stop_q;
  logic                msb_q, invd_q;
  logic [MAX_BITS-1:0] shreg, shreg_nxt;
  logic [NB_W-1:0]     bit_cnt;

  logic [TMR_W-1:0]    per, half, quarter, stop_off;
  logic                has_par, dbit, exp_par;
  logic                ev_v;
  evt_e                ev_t;
  logic [MAX_BITS-1:0] ev_d;

  assign nb_in = (cfg_data_bits < NB_W'(MIN_BITS)) ? NB_W'(MIN_BITS) :
                 (cfg_data_bits > NB_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : cfg_data_bits;

  assign per     = TMR_W'(cpb_q);
  assign half    = per >> 1;
  assign quarter = per >> 2;

  always_comb begin
    case (stop_q)
      STOP_HALF:     stop_off = half + quarter;
      STOP_ONE:      stop_off = per;
      STOP_ONE_HALF: stop_off = per + quarter;
      default:       stop_off = per + half;
    endcase
  end

  assign has_par = (par_q == PAR_ODD) || (par_q == PAR_EVEN) ||
                   (par_q == PAR_MARK) || (par_q == PAR_SPACE);
  assign dbit    = line ^ invd_q;

  always_comb begin
    case (par_q)
      PAR_ODD:  exp_par = ~(^shreg);
      PAR_EVEN: exp_par = ^shreg;
      PAR_MARK: exp_par = 1'b1;
      default:  exp_par = 1'b0;
    endcase
  end

  always_comb begin
    if (msb_q) shreg_nxt = {shreg[MAX_BITS-2:0], dbit};
    else       shreg_nxt = (shreg >> 1) | (MAX_BITS'(dbit) << (nb_q - 1'b1));
  end

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ev_v     = 1'b0;
    ev_t     = EV_START;
    ev_d     = '0;
    case (state)
      ST_IDLE: if (fall) begin
        nxt      = ST_START;
        tmr_load = 1'b1;
        tmr_val  = (TMR_W'(cfg_clks_per_bit) >> 1) - 1'b1;
      end
      ST_START: if (tick) begin
        ev_v = 1'b1;
        if (!line) begin
          nxt      = ST_DATA;
          tmr_load = 1'b1;
          tmr_val  = per - 1'b1;
        end else begin
          ev_t = EV_BAD_START;
          ev_d = MAX_BITS'(1);
          nxt  = ST_IDLE;
        end
      end
      ST_DATA: if (tick) begin
        tmr_load = 1'b1;
        tmr_val  = per - 1'b1;
        if (bit_cnt == nb_q - 1'b1) begin
          ev_v = 1'b1;
          ev_t = EV_DATA;
          ev_d = shreg_nxt;
          if (has_par) begin
            nxt = ST_PAR;
          end else begin
            nxt     = ST_STOP;
            tmr_val = stop_off - 1'b1;
          end
        end
      end
      ST_PAR: if (tick) begin
        ev_v     = 1'b1;
        nxt      = ST_STOP;
        tmr_load = 1'b1;
        tmr_val  = stop_off - 1'b1;
        if (dbit == exp_par) begin
          ev_t = EV_PARITY;
          ev_d = MAX_BITS'(dbit);
        end else begin
          ev_t = EV_PAR_ERR;
          ev_d = MAX_BITS'({exp_par, dbit});
        end
      end
      ST_STOP: if (tick) begin
        ev_v = 1'b1;
        nxt  = ST_IDLE;
        ev_t = line ? EV_STOP : EV_BAD_STOP;
        ev_d = MAX_BITS'(line);
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cpb_q     <= '0;
      nb_q      <= NB_W'(8);
      par_q     <= PAR_NONE;
      stop_q    <= STOP_ONE;
      msb_q     <= 1'b0;
      invd_q    <= 1'b0;
      shreg     <= '0;
      bit_cnt   <= '0;
      evt_valid <= 1'b0;
      evt_type  <= '0;
      evt_data  <= '0;
    end else begin
      state     <= nxt;
      evt_valid <= ev_v;
      evt_type  <= ev_t;
      evt_data  <= ev_d;
      if (state == ST_IDLE) begin
        cpb_q  <= cfg_clks_per_bit;
        nb_q   <= nb_in;
        par_q  <= par_e'(cfg_parity);
        stop_q <= stop_e'(cfg_stop);
        msb_q  <= cfg_msb_first;
        invd_q <= cfg_invert_data;
      end
      if (state == ST_START && tick) begin
        shreg   <= '0;
        bit_cnt <= '0;
      end
      if (state == ST_DATA && tick) begin
        shreg   <= shreg_nxt;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R2: a rejected start leaves the receiver idle
  assert_bad_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type == EV_BAD_START) |-> state == ST_IDLE);
  // R3: data payload never exceeds the captured width
  assert_data_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type == EV_DATA) |-> ((evt_data >> nb_q) == '0));
  // R5: without parity the data event leads straight into the stop bit
  assert_no_par_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type == EV_DATA && !has_par) |-> state == ST_STOP);
  // R10: captured settings hold while a frame is in progress
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(cpb_q) && $stable(nb_q) && $stable(par_q) &&
                            $stable(stop_q) && $stable(msb_q) && $stable(invd_q)));
  // R11: events are isolated single-cycle pulses
  assert_evt_isolated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
endmodule

// File: rtl/serial_frame_rx.sv
`timescale 1ns/1ps
module serial_frame_rx #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_BITS    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_line,
  input  logic [CNT_W-1:0]    cfg_clks_per_bit,
  input  logic [3:0]          cfg_data_bits,
  input  logic [2:0]          cfg_parity,
  input  logic [1:0]          cfg_stop,
  input  logic                cfg_msb_first,
  input  logic                cfg_invert_line,
  input  logic                cfg_invert_data,
  output logic                evt_valid,
  output logic [2:0]          evt_type,
  output logic [MAX_BITS-1:0] evt_data
);
  localparam int unsigned TMR_W = CNT_W + 1;

  logic             line, fall, tick, tmr_load;
  logic [TMR_W-1:0] tmr_val;

  sfr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .invert(cfg_invert_line),
    .line(line), .fall(fall)
  );

  sfr_bit_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .tick(tick)
  );

  sfr_frame_ctrl #(.CNT_W(CNT_W), .MAX_BITS(MAX_BITS), .TMR_W(TMR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .line(line), .fall(fall), .tick(tick),
    .cfg_clks_per_bit(cfg_clks_per_bit), .cfg_data_bits(cfg_data_bits),
    .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_invert_data(cfg_invert_data), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .evt_valid(evt_valid), .evt_type(evt_type), .evt_data(evt_data)
  );
endmodule

// File: tb/serial_frame_rx_tb.sv
`timescale 1ns/1ps
module serial_frame_rx_tb_top;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_raw = 1'b1;
  logic [15:0] cfg_cpb = 16'(N);
  logic [3:0] cfg_nb = 4'd8;
  logic [2:0] cfg_par = 3'd0;
  logic [1:0] cfg_stop = 2'd1;
  logic       cfg_msb = 1'b0, cfg_invl = 1'b0, cfg_invd = 1'b0;
  logic       evt_valid;
  logic [2:0] evt_type;
  logic [8:0] evt_data;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int q_n = 0;
  int q_t[16], q_d[16], q_c[16];

  always #4 clk = ~clk;

  serial_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(line_raw), .cfg_clks_per_bit(cfg_cpb),
    .cfg_data_bits(cfg_nb), .cfg_parity(cfg_par), .cfg_stop(cfg_stop),
    .cfg_msb_first(cfg_msb), .cfg_invert_line(cfg_invl), .cfg_invert_data(cfg_invd),
    .evt_valid(evt_valid), .evt_type(evt_type), .evt_data(evt_data)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && evt_valid && q_n < 16) begin
      q_t[q_n] = int'(evt_type);
      q_d[q_n] = int'(evt_data);
      q_c[q_n] = cyc;
      q_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic drive(input bit lvl, input int cycles);
    line_raw = lvl ^ cfg_invl;
    repeat (cycles) @(negedge clk);
  endtask

  function automatic int stop_len(input int s);
    case (s)
      0: return N / 2;
      1: return N;
      2: return N + N / 2;
      default: return 2 * N;
    endcase
  endfunction

  function automatic int stop_off(input int s);
    return N / 2 + stop_len(s) / 2;
  endfunction

  function automatic bit par_bit(input int par, input int val);
    int ones = $countones(val);
    case (par)
      1: return (ones % 2) == 0;
      2: return (ones % 2) == 1;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_inv(input bit v);
    cfg_invl = v;
    line_raw = 1'b1 ^ v;
    repeat (3 * N) @(negedge clk);
  endtask

  task automatic run_frame(input int nb, input int val, input int par, input bit msb,
                           input int stopm, input bit invd, input bit flip,
                           input bit stop_lvl, input bit scramble, input string req);
    int et[4], ed[4], en, t0, p, rp;
    bit has_p;
    cfg_cpb = 16'(N); cfg_nb = 4'(nb); cfg_par = 3'(par); cfg_msb = msb;
    cfg_stop = 2'(stopm); cfg_invd = invd;
    repeat (2 * N) @(negedge clk);
    q_n = 0;
    t0 = cyc;
    drive(1'b0, 4);
    if (scramble) begin
      cfg_cpb = 16'd12; cfg_nb = (nb == 5) ? 4'd9 : 4'd5; cfg_par = 3'((par + 1) % 5);
      cfg_msb = ~msb; cfg_stop = 2'((stopm + 1) % 4); cfg_invd = ~invd;
    end
    drive(1'b0, N - 4);
    for (int i = 0; i < nb; i++) begin
      bit b = msb ? val[nb-1-i] : val[i];
      drive(b ^ invd, N);
    end
    has_p = (par >= 1 && par <= 4);
    p = par_bit(par, val);
    rp = p ^ flip;
    if (has_p) drive(1'(rp) ^ invd, N);
    drive(stop_lvl, stop_len(stopm));
    drive(1'b1, 3 * N);
    en = 0;
    et[en] = 0; ed[en] = 0; en++;
    et[en] = 1; ed[en] = val; en++;
    if (has_p) begin
      if (flip) begin et[en] = 6; ed[en] = p * 2 + rp; end
      else      begin et[en] = 2; ed[en] = rp; end
      en++;
    end
    et[en] = stop_lvl ? 3 : 5; ed[en] = stop_lvl ? 1 : 0; en++;
    chk(q_n == en, req, "event count", q_n, en);
    for (int k = 0; k < en && k < q_n; k++) begin
      chk(q_t[k] == et[k], req, "event type", q_t[k], et[k]);
      chk(q_d[k] == ed[k], req, "event payload", q_d[k], ed[k]);
    end
    if (q_n == en) begin
      chk(q_c[0] - t0 >= N / 2 + 1 && q_c[0] - t0 <= N / 2 + 5, "R1",
          "start event delay", q_c[0] - t0, N / 2 + 3);
      chk(q_c[1] - q_c[0] == nb * N, "R12", "data event spacing",
          q_c[1] - q_c[0], nb * N);
      chk(q_c[en-1] - q_c[1] == (has_p ? N : 0) + stop_off(stopm), "R7",
          "stop event spacing", q_c[en-1] - q_c[1], (has_p ? N : 0) + stop_off(stopm));
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(evt_valid == 1'b0, "R11", "evt_valid in reset", int'(evt_valid), 0);
    rst_n = 1'b1;
    q_n = 0;
    repeat (10) @(negedge clk);
    chk(q_n == 0, "R11", "events after reset", q_n, 0);

    // R3 R4 R5 R6: width x parity x order sweep
    for (int nb = 5; nb <= 9; nb++)
      for (int par = 0; par <= 4; par++)
        for (int msb = 0; msb <= 1; msb++)
          for (int v = 0; v < 4; v++) begin
            int mask = (1 << nb) - 1;
            int val = (v == 0) ? 0 : (v == 1) ? mask : (v == 2) ? (32'h155 & mask)
                                                              : ((nb * 37 + par * 11 + msb) & mask);
            run_frame(nb, val, par, 1'(msb), 1, 1'b0, 1'b0, 1'b1, 1'b0,
                      msb ? "R4" : "R3");
          end

    // R3: every byte value, 8 bits, LSB first, no parity
    for (int v = 0; v < 256; v++)
      run_frame(8, v, 0, 1'b0, 1, 1'b0, 1'b0, 1'b1, 1'b0, "R3");

    // R7: stop lengths with good and bad stop levels, with and without parity
    for (int s = 0; s < 4; s++)
      for (int lvl = 0; lvl <= 1; lvl++) begin
        run_frame(8, 8'hA5, 0, 1'b0, s, 1'b0, 1'b0, 1'(lvl), 1'b0, "R7");
        run_frame(7, 7'h2C, 2, 1'b1, s, 1'b0, 1'b0, 1'(lvl), 1'b0, "R7");
      end

    // R6: forced parity mismatches in all four modes
    for (int par = 1; par <= 4; par++)
      for (int v = 0; v < 3; v++)
        run_frame(8, (v * 91 + par) & 255, par, 1'b0, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R6");

    // R5: codes 5..7 behave as no parity
    for (int par = 5; par <= 7; par++)
      run_frame(6, 6'h2B, par, 1'b0, 1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");

    // R2: a short glitch gives an invalid start, then a normal frame follows
    repeat (2 * N) @(negedge clk);
    q_n = 0;
    drive(1'b0, 2);
    drive(1'b1, 3 * N);
    chk(q_n == 1, "R2", "glitch event count", q_n, 1);
    chk(q_t[0] == 4, "R2", "glitch event type", q_t[0], 4);
    chk(q_d[0] == 1, "R2", "glitch payload", q_d[0], 1);
    run_frame(8, 8'h3C, 1, 1'b0, 1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");

    // R8: inverted line, idle low
    set_inv(1'b1);
    run_frame(8, 8'h81, 2, 1'b0, 1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    run_frame(9, 9'h1F0, 1, 1'b1, 3, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    run_frame(5, 5'h0A, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    set_inv(1'b0);

    // R9: data and parity inverted, start and stop normal
    run_frame(8, 8'h5A, 1, 1'b0, 1, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
    run_frame(8, 8'h00, 3, 1'b1, 2, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
    run_frame(7, 7'h71, 2, 1'b0, 1, 1'b1, 1'b1, 1'b1, 1'b0, "R9");

    // R10: settings changed mid-frame have no effect on that frame
    run_frame(8, 8'hC3, 2, 1'b0, 1, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
    run_frame(5, 5'h13, 0, 1'b1, 3, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
    run_frame(9, 9'h0FF, 4, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule